// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

This block governs the start-up of a step-down switching regulator. It counts switching cycles, reported to it as a one-clock strobe per cycle, and walks the converter through a fixed ramp of equal-length stages. Each stage allows a larger fraction of the valley current limit. The sequence starts once the regulator is enabled and its bias supply has cleared under-voltage lockout. It ends with a completion flag that downstream logic uses to arm output under-voltage and power-good monitoring.

The block does not drive the power stage. It supplies a current-limit scaling code to the analog limit circuit. It raises two first-stage helpers: one doubles the minimum off-time, and the other tells the on-time generator to add a positive offset to its sensed output. It also requests that the first switching pulse be a low-side pulse, so that the bootstrap capacitor charges before the high-side switch is used. Dropping either the enable or the bias-ready input abandons the ramp. When both inputs are next present, the ramp restarts from the beginning.

Top module: `ss_seq`

## Requirements
- R1: While reset is asserted, and in every cycle after one in which `enable` or `biasReady` was sampled low, `ilimCode` is 0 and `dblOffTime`, `offsetAssist`, `firstLowSide` and `ssDone` are all low.
- R2: During the ramp, `ilimCode` equals the number of completed stages, where a stage is STAGE_CYCLES strobes. Code k means a current limit of (k+1)/NUM_STAGES of full scale, so with four stages the codes 0, 1, 2 and 3 mean 25, 50, 75 and 100 percent.
- R3: `dblOffTime` and `offsetAssist` are high throughout the first stage (code 0 while ramping) and low in every later stage and after completion.
- R4: Only `cycleStrobe` advances the ramp, and each strobe sampled while ramping counts exactly once. Strobes sampled while idle are ignored. The ramp begins one clock after `enable` and `biasReady` are first both sampled high.
- R5: `ssDone` rises in the clock after the strobe that completes NUM_STAGES×STAGE_CYCLES strobes. It then stays high with `ilimCode` at NUM_STAGES-1 and the first-stage flags low, regardless of further strobes, for as long as both `enable` and `biasReady` stay high.
- R6: `firstLowSide` is high from the first ramping cycle until the first counted strobe, and low otherwise.
- R7: Deasserting `enable` at any point of the ramp or after completion returns the block to the idle outputs of R1. When `enable` is reasserted, the ramp restarts from a cycle count of zero.
- R8: The same holds for `biasReady`: the stage and cycle counters are cleared while the lockout is active, and the ramp starts from zero when the lockout releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleStrobe | input | 1 | One-clock pulse per switching cycle |
| enable | input | 1 | Regulator enable |
| biasReady | input | 1 | Bias supply has cleared under-voltage lockout |
| ilimCode | output | $clog2(NUM_STAGES) | Current-limit scaling code |
| dblOffTime | output | 1 | Double the minimum off-time |
| offsetAssist | output | 1 | Add the start-up offset to the on-time sense input |
| firstLowSide | output | 1 | Next pulse must be a low-side pulse |
| ssDone | output | 1 | Soft-start ramp complete |

## Verification
The bench builds the block with STAGE_CYCLES = 6 and the default four stages. The full ramp is then only 24 strobes, so the bench can check every strobe count from zero past completion against expected outputs derived arithmetically from the strobe count. The sweep is run twice: once with strobes separated by varying idle gaps, and once with back-to-back strobes. This exercises every stage boundary, the hold between strobes and the sticky completion state. Aborts by `enable` and by `biasReady` are applied mid-ramp, and strobes are applied while idle, so that restart from zero and the ignore behaviour are both observed at the ports.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_RUN  = 2'd1,
    SS_DONE = 2'd2
  } ssState_t;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic clrAll;
    logic incCycle;
    logic advStage;
  } ssCtrl_t;

endpackage

// File: rtl/ss_seq_dpath.sv
module ss_seq_dpath
  import ss_seq_pkg::*;
#(
  parameter int STAGE_CYCLES = 110,
  parameter int NUM_STAGES   = 4,
  localparam int CNT_W = (STAGE_CYCLES > 1) ? $clog2(STAGE_CYCLES) : 1,
  localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ssCtrl_t          ctrl,
  output logic             cntAtEnd,
  output logic             lastStage,
  output logic [STG_W-1:0] stageIdx
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAGE_CYCLES - 1);
  localparam logic [STG_W-1:0] STG_LAST = STG_W'(NUM_STAGES - 1);

  logic [CNT_W-1:0] cycleCnt;

  assign cntAtEnd  = (cycleCnt == CNT_LAST);
  assign lastStage = (stageIdx == STG_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clrAll) begin
      cycleCnt <= '0;
    end else if (ctrl.incCycle) begin
      cycleCnt <= cntAtEnd ? '0 : cycleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clrAll) begin
      stageIdx <= '0;
    end else if (ctrl.advStage && !lastStage) begin
      stageIdx <= stageIdx + 1'b1;
    end
  end

endmodule

// File: rtl/ss_seq_ctrl.sv
module ss_seq_ctrl
  import ss_seq_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleStrobe,
  input  logic             enable,
  input  logic             biasReady,
  input  logic             cntAtEnd,
  input  logic             lastStage,
  input  logic [STG_W-1:0] stageIdx,
  output ssCtrl_t          ctrl,
  output logic [STG_W-1:0] ilimCode,
  output logic             dblOffTime,
  output logic             offsetAssist,
  output logic             firstLowSide,
  output logic             ssDone
);

  localparam logic [STG_W-1:0] STG_TOP = STG_W'(NUM_STAGES - 1);

  ssState_t state, stateNext;
  logic     active;
  logic     pulseSeen;
  logic     rampEnd;

  assign active  = enable && biasReady;
  assign rampEnd = (state == SS_RUN) && cycleStrobe && cntAtEnd && lastStage;

  always_comb begin
    ctrl.clrAll   = !active || (state == SS_IDLE);
    ctrl.incCycle = (state == SS_RUN) && cycleStrobe;
    ctrl.advStage = (state == SS_RUN) && cycleStrobe && cntAtEnd;
  end

  always_comb begin
    stateNext = state;
    if (!active) begin
      stateNext = SS_IDLE;
    end else begin
      unique case (state)
        SS_IDLE: stateNext = SS_RUN;
        SS_RUN:  if (rampEnd) stateNext = SS_DONE;
        SS_DONE: stateNext = SS_DONE;
        default: stateNext = SS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SS_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || state != SS_RUN || !active) begin
      pulseSeen <= 1'b0;
    end else if (cycleStrobe) begin
      pulseSeen <= 1'b1;
    end
  end

  always_comb begin
    ilimCode     = '0;
    dblOffTime   = 1'b0;
    offsetAssist = 1'b0;
    firstLowSide = 1'b0;
    ssDone       = 1'b0;
    unique case (state)
      SS_RUN: begin
        ilimCode     = stageIdx;
        dblOffTime   = (stageIdx == '0);
        offsetAssist = (stageIdx == '0);
        firstLowSide = !pulseSeen;
      end
      SS_DONE: begin
        ilimCode = STG_TOP;
        ssDone   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ss_seq.sv
module ss_seq
  import ss_seq_pkg::*;
#(
  parameter int STAGE_CYCLES = 110,
  parameter int NUM_STAGES   = 4,
  localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleStrobe,
  input  logic             enable,
  input  logic             biasReady,
  output logic [STG_W-1:0] ilimCode,
  output logic             dblOffTime,
  output logic             offsetAssist,
  output logic             firstLowSide,
  output logic             ssDone
);

  ssCtrl_t          ctrl;
  logic             cntAtEnd;
  logic             lastStage;
  logic [STG_W-1:0] stageIdx;

  ss_seq_ctrl #(.NUM_STAGES(NUM_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe),
    .enable(enable), .biasReady(biasReady),
    .cntAtEnd(cntAtEnd), .lastStage(lastStage), .stageIdx(stageIdx),
    .ctrl(ctrl), .ilimCode(ilimCode), .dblOffTime(dblOffTime),
    .offsetAssist(offsetAssist), .firstLowSide(firstLowSide), .ssDone(ssDone)
  );

  ss_seq_dpath #(.STAGE_CYCLES(STAGE_CYCLES), .NUM_STAGES(NUM_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .cntAtEnd(cntAtEnd), .lastStage(lastStage), .stageIdx(stageIdx)
  );

endmodule

// File: rtl/ss_seq_chk.sv
module ss_seq_chk #(
  parameter int NUM_STAGES = 4,
  localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycleStrobe,
  input logic             enable,
  input logic             biasReady,
  input logic [STG_W-1:0] ilimCode,
  input logic             dblOffTime,
  input logic             offsetAssist,
  input logic             firstLowSide,
  input logic             ssDone
);

  localparam logic [STG_W-1:0] TOP = STG_W'(NUM_STAGES - 1);

  AST_IDLE_AFTER_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && biasReady) |=> (ilimCode == '0) && !dblOffTime && !offsetAssist
                               && !firstLowSide && !ssDone); // R1

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && biasReady) |=> (ilimCode == $past(ilimCode))
                             || (ilimCode == $past(ilimCode) + 1'b1)); // R2

  AST_ASSIST_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (dblOffTime || offsetAssist) |-> (ilimCode == '0) && !ssDone
                                     && (dblOffTime == offsetAssist)); // R3

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!cycleStrobe && enable && biasReady) |=> $stable(ilimCode) && $stable(ssDone)); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ssDone && enable && biasReady) |=> ssDone && (ilimCode == TOP)); // R5

  AST_FIRST_LOW_START: assert property (@(posedge clk) disable iff (!rstN)
    firstLowSide |-> (ilimCode == '0) && !ssDone); // R6

  AST_FIRST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (firstLowSide && cycleStrobe) |=> !firstLowSide); // R6

endmodule

bind ss_seq ss_seq_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .enable(enable),
  .biasReady(biasReady), .ilimCode(ilimCode), .dblOffTime(dblOffTime),
  .offsetAssist(offsetAssist), .firstLowSide(firstLowSide), .ssDone(ssDone)
);

// File: tb/ss_seq_bench.sv
module ss_seq_bench;

  localparam int SC    = 6;
  localparam int NS    = 4;
  localparam int TOTAL = SC * NS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycleStrobe = 1'b0;
  logic       enable = 1'b0;
  logic       biasReady = 1'b0;
  logic [1:0] ilimCode;
  logic       dblOffTime, offsetAssist, firstLowSide, ssDone;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ss_seq #(.STAGE_CYCLES(SC), .NUM_STAGES(NS)) u_ss_seq (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .enable(enable),
    .biasReady(biasReady), .ilimCode(ilimCode), .dblOffTime(dblOffTime),
    .offsetAssist(offsetAssist), .firstLowSide(firstLowSide), .ssDone(ssDone)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expectIdle(input string req);
    chk({req, " code"}, ilimCode, 0);
    chk({req, " flags"}, {dblOffTime, offsetAssist, firstLowSide, ssDone}, 0);
  endtask

  // expected outputs after n counted strobes since the ramp began
  task automatic expectAt(input int n);
    int stg;
    if (n >= TOTAL) begin
      chk("R5 done", ssDone, 1);
      chk("R5 code", ilimCode, NS - 1);
      chk("R5 flags", {dblOffTime, offsetAssist, firstLowSide}, 0);
    end else begin
      stg = n / SC;
      chk("R2 code", ilimCode, stg);
      chk("R3 dblOffTime", dblOffTime, (stg == 0) ? 1 : 0);
      chk("R3 offsetAssist", offsetAssist, (stg == 0) ? 1 : 0);
      chk("R6 firstLowSide", firstLowSide, (n == 0) ? 1 : 0);
      chk("R5 not done", ssDone, 0);
    end
  endtask

  task automatic strobe(input int gap);
    cycleStrobe = 1'b1;
    @(negedge clk);
    cycleStrobe = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectIdle("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    expectIdle("R1 after reset");

    // bias ready but not enabled: strobes ignored
    biasReady = 1'b1;
    for (int i = 0; i < 4; i++) strobe(1);
    expectIdle("R4 strobe while idle");

    // enable: one clock to enter the ramp
    enable = 1'b1;
    @(negedge clk);
    expectAt(0);

    // sweep with varying gaps; check after each strobe and after the gap
    for (int n = 1; n <= TOTAL + 4; n++) begin
      cycleStrobe = 1'b1;
      @(negedge clk);
      cycleStrobe = 1'b0;
      expectAt(n);
      repeat (n % 3) @(negedge clk);
      expectAt(n); // R4 hold between strobes
    end

    // disable after completion, then restart
    enable = 1'b0;
    @(negedge clk);
    expectIdle("R7 disable after done");
    enable = 1'b1;
    @(negedge clk);
    expectAt(0);

    // abort by enable mid-ramp
    for (int i = 0; i < 8; i++) strobe(0);
    expectAt(8);
    enable = 1'b0;
    @(negedge clk);
    expectIdle("R7 disable mid-ramp");
    strobe(0);
    expectIdle("R7 strobe while disabled");
    enable = 1'b1;
    @(negedge clk);
    expectAt(0);
    strobe(0);
    expectAt(1); // R7 restarted from zero

    // abort by lockout mid-ramp
    for (int i = 0; i < 14; i++) strobe(0);
    expectAt(15);
    biasReady = 1'b0;
    @(negedge clk);
    expectIdle("R8 lockout mid-ramp");
    strobe(1);
    expectIdle("R8 strobe during lockout");
    biasReady = 1'b1;
    @(negedge clk);
    expectAt(0);

    // back-to-back sweep after lockout release
    for (int n = 1; n <= TOTAL + 2; n++) begin
      cycleStrobe = 1'b1;
      @(negedge clk);
      expectAt(n); // R8 ramp from zero, R5 completion
    end
    cycleStrobe = 1'b0;
    @(negedge clk);
    expectAt(TOTAL);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule